// File: doc/BRIEF.md
# Supply Reset Sequencer With Undervoltage Deglitch

This block produces the system's active-low reset from two digital causes. The first is an undervoltage flag that an analog comparator elsewhere has already formed, and which may arrive asynchronously. The second is a one-cycle violation pulse from a window watchdog.

The flag is synchronised first. It then has to stay high for a programmable number of clock ticks before it counts as a real undervoltage event, so brief dips are rejected. While a qualified undervoltage is present, reset is held. Once the flag has been clear, reset is released only after a programmable delay, during which the flag must stay continuously clear. A new dip during that delay restarts it. A watchdog violation turns reset on for exactly one delay period. A complementary reset-active level goes back to the watchdog, so that it can stay idle for the whole reset.

All times are counted in clock ticks and set by parameters.

Top module: `supply_reset_sequencer`

## Requirements
- R1: While `rst` is high, and after it falls until the release delay has elapsed, `rst_n_out` is 0 and `rst_active` is 1.
- R2: With `uv_raw` held at 0, `rst_n_out` rises exactly DELAY_TICKS clock edges after the last edge at which `rst` was high.
- R3: A high pulse on `uv_raw` lasting fewer than GLITCH_TICKS clock cycles leaves `rst_n_out` at 1.
- R4: A high level on `uv_raw` lasting GLITCH_TICKS cycles or more drives `rst_n_out` to 0 exactly SYNC_STAGES+GLITCH_TICKS+1 cycles after the input rises.
- R5: While a qualified undervoltage is present, `rst_n_out` stays 0 whatever happens on `wd_fault`.
- R6: After `uv_raw` falls, `rst_n_out` rises SYNC_STAGES+2+DELAY_TICKS cycles later. A qualified dip during the delay discards the count, which starts again from zero once the flag clears.
- R7: A `wd_fault` pulse sampled while reset is released drives `rst_n_out` to 0 for exactly DELAY_TICKS cycles.
- R8: A `wd_fault` pulse that arrives while reset is already active does not lengthen the reset in progress.
- R9: `rst_active` is the complement of `rst_n_out` on every cycle.
- R10: The glitch counter clears whenever the synchronised flag drops, so two short pulses separated by a one-cycle gap do not add up to a qualified event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all tick counts refer to it |
| rst | input | 1 | Synchronous active-high reset |
| uv_raw | input | 1 | Asynchronous supply-below-threshold flag, 1 = undervoltage |
| wd_fault | input | 1 | Watchdog violation, one-cycle high pulse |
| rst_n_out | output | 1 | Registered reset output, 0 = reset asserted |
| rst_active | output | 1 | Registered reset-active level to the watchdog, 1 = in reset |

## Verification
The checker covers the properties that hold on every cycle:
- `rst_active` mirrors the reset output.
- A qualified undervoltage forces reset on the next cycle.
- A watchdog pulse in the released state pulls reset low.
- A drop of the synchronised flag clears the qualified flag.
- Every release is preceded by at least DELAY_TICKS clean cycles.

Only the bench scenarios can show the exact latencies and the two glitch boundaries (GLITCH_TICKS-1 against GLITCH_TICKS). They also show that the delay restarts on a dip, and that an overlapping watchdog pulse does not extend an active reset. A cycle-level reference model is compared against both outputs under random undervoltage bursts and watchdog pulses.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_deglitch.sv
module rsq_deglitch #(
  parameter int GLITCH_TICKS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic level_qual
);
  localparam int CW = $clog2(GLITCH_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_TICKS - 1);

  logic [CW-1:0] run_q;
  logic          qual_q;

  // Count consecutive high cycles; any low cycle clears the run (R10).
  always_ff @(posedge clk) begin
    if (rst || !level_in) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (run_q == LAST) begin
      qual_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_qual = qual_q;
endmodule

// File: rtl/rsq_release.sv
module rsq_release
  import rsq_pkg::*;
#(
  parameter int DELAY_TICKS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_qual,
  input  logic wd_fault,
  output logic rst_n_q,
  output logic active_q
);
  localparam int DW = $clog2(DELAY_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DELAY_TICKS - 1);

  seq_state_t    state_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_DELAY;
      cnt_q    <= '0;
      rst_n_q  <= 1'b0;
      active_q <= 1'b1;
    end else begin
      case (state_q)
        SEQ_HOLD: begin
          if (!uv_qual) begin
            state_q <= SEQ_DELAY;
            cnt_q   <= '0;
          end
        end
        SEQ_DELAY: begin
          if (uv_qual) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
          end else if (cnt_q == LAST) begin
            state_q  <= SEQ_RUN;
            rst_n_q  <= 1'b1;
            active_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_RUN: begin
          if (uv_qual) begin
            state_q  <= SEQ_HOLD;
            cnt_q    <= '0;
            rst_n_q  <= 1'b0;
            active_q <= 1'b1;
          end else if (wd_fault) begin
            state_q  <= SEQ_DELAY;
            cnt_q    <= '0;
            rst_n_q  <= 1'b0;
            active_q <= 1'b1;
          end
        end
        default: begin
          state_q  <= SEQ_HOLD;
          cnt_q    <= '0;
          rst_n_q  <= 1'b0;
          active_q <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer #(
  parameter int SYNC_STAGES  = 2,
  parameter int GLITCH_TICKS = 6,
  parameter int DELAY_TICKS  = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_raw,
  input  logic wd_fault,
  output logic rst_n_out,
  output logic rst_active
);
  logic uv_sync;
  logic uv_filt;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (uv_raw),
    .q_sync  (uv_sync)
  );

  rsq_deglitch #(.GLITCH_TICKS(GLITCH_TICKS)) u_deglitch (
    .clk        (clk),
    .rst        (rst),
    .level_in   (uv_sync),
    .level_qual (uv_filt)
  );

  rsq_release #(.DELAY_TICKS(DELAY_TICKS)) u_release (
    .clk      (clk),
    .rst      (rst),
    .uv_qual  (uv_filt),
    .wd_fault (wd_fault),
    .rst_n_q  (rst_n_out),
    .active_q (rst_active)
  );
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int DELAY_TICKS = 40
) (
  input logic clk,
  input logic rst,
  input logic uv_sync,
  input logic uv_filt,
  input logic wd_fault,
  input logic rst_n_out,
  input logic rst_active
);
  int unsigned clean_cnt;

  // Cycles with reset held and no qualified undervoltage since the last disturbance.
  always_ff @(posedge clk) begin
    if (rst || rst_n_out || uv_filt) clean_cnt <= 0;
    else                             clean_cnt <= clean_cnt + 1;
  end

  assert_active_mirror_R9: assert property (@(posedge clk) disable iff (rst)
    rst_active == !rst_n_out);

  assert_uv_holds_R5: assert property (@(posedge clk) disable iff (rst)
    uv_filt |=> !rst_n_out);

  assert_wd_pulls_R7: assert property (@(posedge clk) disable iff (rst)
    (rst_n_out && wd_fault && !uv_filt) |=> !rst_n_out);

  assert_clear_on_drop_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(uv_sync) |=> !uv_filt);

  assert_full_delay_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> (clean_cnt >= DELAY_TICKS));
endmodule

bind supply_reset_sequencer rsq_checker #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .uv_sync    (uv_sync),
  .uv_filt    (uv_filt),
  .wd_fault   (wd_fault),
  .rst_n_out  (rst_n_out),
  .rst_active (rst_active)
);

// File: tb/supply_reset_sequencer_tb_top.sv
module supply_reset_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2;
  localparam int G = 6;
  localparam int D = 40;

  logic clk = 1'b0;
  logic rst, uv_raw, wd_fault;
  logic rst_n_out, rst_active;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  supply_reset_sequencer #(.SYNC_STAGES(S), .GLITCH_TICKS(G), .DELAY_TICKS(D)) dut_i (
    .clk(clk), .rst(rst), .uv_raw(uv_raw), .wd_fault(wd_fault),
    .rst_n_out(rst_n_out), .rst_active(rst_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirement latencies.
  logic m_s1, m_s2, m_filt, m_out, m_hold;
  int   m_run, m_cnt;
  always @(posedge clk) begin
    int run_n;
    cyc <= cyc + 1;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_run <= 0; m_filt <= 0;
      m_out <= 0; m_hold <= 0; m_cnt <= 0;
    end else begin
      m_s1 <= uv_raw;
      m_s2 <= m_s1;
      run_n = m_s2 ? ((m_run < G) ? m_run + 1 : G) : 0;
      m_run  <= run_n;
      m_filt <= (run_n >= G);
      if (m_filt) begin
        m_out <= 0; m_hold <= 1; m_cnt <= 0;
      end else if (m_out) begin
        if (wd_fault) begin m_out <= 0; m_cnt <= 0; end
      end else if (m_hold) begin
        m_hold <= 0; m_cnt <= 0;
      end else if (m_cnt == D-1) begin
        m_out <= 1;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison with the model.
  always @(negedge clk) begin
    if (cyc > 0) begin
      check(rst_n_out === m_out, cur_req, int'(rst_n_out), int'(m_out));
      check(rst_active === !rst_n_out, "R9", int'(rst_active), int'(!rst_n_out));
    end
  end

  // Watchdog for a hung run.
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_until_high(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_n_out && n < 10000);
  endtask

  task automatic count_until_low(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst_n_out && n < 10000);
  endtask

  task automatic watch_high(input int n, input string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rst_n_out) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  initial begin
    int n;
    int uv_len;
    void'($urandom(32'h5EED));
    rst = 1; uv_raw = 0; wd_fault = 0;
    cycles(3);
    cur_req = "R1";
    check(rst_n_out == 0 && rst_active == 1, "R1", int'(rst_n_out), 0);
    rst = 0;
    cycles(D/2);
    check(rst_n_out == 0, "R1", int'(rst_n_out), 0);
    cur_req = "R2";
    count_until_high(n);
    check(n + D/2 == D, "R2", n + D/2, D);

    // R3: pulse one cycle shorter than the glitch limit
    cur_req = "R3";
    uv_raw = 1; cycles(G-1); uv_raw = 0;
    watch_high(S+G+6, "R3");

    // R10: two short pulses separated by a one-cycle gap
    cur_req = "R10";
    uv_raw = 1; cycles(G-1); uv_raw = 0; cycles(1);
    uv_raw = 1; cycles(G-1); uv_raw = 0;
    watch_high(S+G+6, "R10");

    // R4: qualified undervoltage latency
    cur_req = "R4";
    uv_raw = 1;
    count_until_low(n);
    check(n == S+G+1, "R4", n, S+G+1);

    // R5: watchdog pulses during undervoltage do nothing
    cur_req = "R5";
    for (int k = 0; k < 5; k++) begin
      wd_fault = 1; cycles(1); wd_fault = 0; cycles(D/2);
    end
    check(rst_n_out == 0, "R5", int'(rst_n_out), 0);
    cur_req = "R6";
    uv_raw = 0;
    count_until_high(n);
    check(n == S+2+D, "R6", n, S+2+D);

    // R6: a dip in the middle of the delay restarts it
    uv_raw = 1; cycles(G+4); uv_raw = 0;
    cycles(D/2);
    check(rst_n_out == 0, "R6", int'(rst_n_out), 0);
    uv_raw = 1; cycles(G+4); uv_raw = 0;
    count_until_high(n);
    check(n == S+2+D, "R6", n, S+2+D);

    // R7: watchdog-triggered reset lasts exactly D cycles
    cur_req = "R7";
    wd_fault = 1; @(negedge clk); wd_fault = 0;
    check(rst_n_out == 0 && rst_active == 1, "R7", int'(rst_n_out), 0);
    n = 1;
    do begin @(negedge clk); n++; end while (!rst_n_out && n < 10000);
    check(n == D+1, "R7", n-1, D);

    // R8: second watchdog pulse during an active reset is ignored
    cur_req = "R8";
    wd_fault = 1; @(negedge clk); wd_fault = 0;
    cycles(D/2 - 1);
    wd_fault = 1; @(negedge clk); wd_fault = 0;
    n = D/2 + 1;
    do begin @(negedge clk); n++; end while (!rst_n_out && n < 10000);
    check(n == D+1, "R8", n-1, D);

    // Random mix of undervoltage bursts and watchdog pulses, checked by the model
    cur_req = "R6";
    uv_len = 0;
    for (int i = 0; i < 4000; i++) begin
      if (uv_len > 0) begin
        uv_len--;
        if (uv_len == 0) uv_raw = 0;
      end else if ($urandom % 60 == 0) begin
        uv_raw = 1;
        uv_len = int'($urandom % (2*G)) + 1;
      end
      wd_fault = ($urandom % 40 == 0);
      @(negedge clk);
    end
    uv_raw = 0; wd_fault = 0;
    cycles(D + 20);
    check(rst_n_out == 1, "R2", int'(rst_n_out), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule